// File: doc/BRIEF.md
# Tiled/Linear Surface Copy Engine

This engine moves a two-dimensional surface between a linear buffer and a tiled buffer, in either direction. Both buffers sit behind one 32-bit word memory port. After a start pulse the engine latches its configuration and visits every texel in row-major order. For each texel it presents the texel's untranslated byte address to an external address translator. It takes the translator's scrambled address back and reduces it to an offset inside the tile region. It also derives the matching linear offset. It then copies the texel word by word, or by read-modify-write when the texel is narrower than a word.

The texel size is not configured directly. The engine derives it from the image pitch and the image width. A texel whose tiled offset lands outside the region is dropped without touching memory. A done pulse marks the end of the pass. The engine also reports how many tiled lines the copy spans, so that the surrounding logic can size the tiled buffer.

Top module: `surf_copy_engine`

## Requirements
- R1: With `dir`=0 (decode), every processed texel is read from the tiled buffer and written to the linear buffer. `mem_buf`=1 selects the tiled buffer and `mem_buf`=0 selects the linear buffer.
- R2: With `dir`=1 (encode), every processed texel is read from the linear buffer and written to the tiled buffer.
- R3: Bytes per texel is the integer quotient `img_pitch / img_width`. Only 1, 2, 4, 8 and 16 are legal. Any other quotient makes the pass perform no memory access, yet `done` still pulses.
- R4: A texel of 4, 8 or 16 bytes with texel index i occupies words i·n … i·n+n−1, where n is bytes/4. Each word is read from the source and then written to the destination, so the texel costs 2·n accesses.
- R5: A texel of 1 or 2 bytes with index i occupies word i>>2 at bit shift (i&3)·8, or word i>>1 at shift (i&1)·16. Lanes are little-endian. The engine reads the source word, reads the destination word, then writes the merged destination word, so the texel costs 3 accesses. Other bytes of the destination word keep their value, and `mem_lock` is high on both destination accesses.
- R6: The linear byte offset is row·`img_pitch` + col·bpp. The tiled byte offset is `xlat_tiled_addr` − (`region_base` + `region_offset`). Each offset is divided by bpp, rounding down, to give its texel index.
- R7: A texel whose tiled byte offset is greater than or equal to `region_size` is skipped and causes no memory access.
- R8: Texels are visited row-major for row < `img_height` and col < `img_width` only. A zero width or height ends the pass with no access.
- R9: `busy` rises in the cycle after an accepted `start`. `done` is a single-cycle pulse after the last texel, and `busy` drops after it. Out of reset, `busy`, `done` and `mem_req` are low.
- R10: `tiled_lines` equals the smaller of two values: `img_height` rounded up to a multiple of 64, and ceil((`region_size` − `region_offset`) / `tile_pitch`).
- R11: A raised `mem_req` holds its address, write enable and write data stable until `mem_gnt`. One access completes per granted cycle.
- R12: `xlat_this_addr` = `region_base` + `region_offset` + row·`tile_pitch` + col·bpp for the texel being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass; accepted only when idle |
| dir | input | 1 | 0 decode (tiled to linear), 1 encode (linear to tiled) |
| img_width | input | 16 | Image width in texels |
| img_height | input | 16 | Image height in rows |
| img_pitch | input | 32 | Linear row pitch in bytes |
| tile_pitch | input | 32 | Tiled row pitch in bytes |
| region_base | input | 32 | Tile region base byte address |
| region_offset | input | 32 | Byte offset of the surface inside the region |
| region_size | input | 32 | Region size in bytes |
| xlat_this_addr | output | 32 | Untranslated byte address sent to the translator |
| xlat_tiled_addr | input | 32 | Translated tiled byte address, combinational reply |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_lock | output | 1 | Port held for a read-modify-write |
| mem_buf | output | 1 | 0 linear buffer, 1 tiled buffer |
| mem_addr | output | 32 | Word address inside the selected buffer |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| tiled_lines | output | 32 | Tiled extent of the latched configuration in lines |

## Verification
The bench drives the engine with a scrambling translator and random grant stalls. It aims at the following corner cases:
- Sub-word texels at every lane. A design with a wrong merge would clobber the neighbouring bytes of the destination word.
- A pitch carrying padding that is not a multiple of the texel size. A wrong rounding rule would shift the linear texel index.
- A region too small for the surface. A design that failed to skip would write past the region or raise the access count.
- A quotient of 3. A design that rounded this to a legal size would move data.
- A zero width. A design with a wrong walker would wrap its counters and never finish.
- Access counts per texel size. These expose a wrong word count for 8- and 16-byte texels.

// File: rtl/surf_pkg.sv
package surf_pkg;

    localparam int SC_AW = 32;   // byte/word address width
    localparam int SC_DW = 16;   // image dimension width
    localparam int SC_LW = 3;    // width of log2(bytes per texel)

    typedef enum logic {
        DIR_DECODE = 1'b0,
        DIR_ENCODE = 1'b1
    } dir_e;

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_EVAL,
        MV_RD_SRC,
        MV_RD_DST,
        MV_WR_DST,
        MV_NEXT,
        MV_DONE
    } mv_state_e;

    typedef struct packed {
        logic             dir;
        logic [SC_DW-1:0] width;
        logic [SC_DW-1:0] height;
        logic [SC_AW-1:0] img_pitch;
        logic [SC_AW-1:0] tile_pitch;
        logic [SC_AW-1:0] base;
        logic [SC_AW-1:0] offset;
        logic [SC_AW-1:0] size;
    } cfg_t;

    // legal texel sizes map to log2; ok=0 for anything else
    function automatic logic [SC_LW:0] texel_log2(input logic [SC_AW-1:0] q);
        case (q)
            32'd1:   return {1'b1, 3'd0};
            32'd2:   return {1'b1, 3'd1};
            32'd4:   return {1'b1, 3'd2};
            32'd8:   return {1'b1, 3'd3};
            32'd16:  return {1'b1, 3'd4};
            default: return {1'b0, 3'd0};
        endcase
    endfunction

    // word address of word k of texel idx
    function automatic logic [SC_AW-1:0] texel_word(input logic [SC_AW-1:0] idx,
                                                    input logic [SC_LW-1:0] lg,
                                                    input logic [1:0]       k);
        case (lg)
            3'd0:    return idx >> 2;
            3'd1:    return idx >> 1;
            3'd2:    return idx;
            3'd3:    return (idx << 1) + SC_AW'(k);
            default: return (idx << 2) + SC_AW'(k);
        endcase
    endfunction

    // bit position of a sub-word texel inside its word
    function automatic logic [4:0] lane_shift(input logic [SC_AW-1:0] idx,
                                              input logic [SC_LW-1:0] lg);
        case (lg)
            3'd0:    return {idx[1:0], 3'b000};
            3'd1:    return {idx[0], 4'b0000};
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/surf_cfg.sv
module surf_cfg
    import surf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  cfg_t             cfg_in,
    output cfg_t             cfg,
    output logic [SC_LW-1:0] bpp_lg,
    output logic             bpp_ok,
    output logic [SC_AW-1:0] tiled_lines
);
    localparam logic [SC_AW-1:0] LINE_ALIGN = SC_AW'(64);

    logic [SC_AW-1:0] quot;
    logic [SC_LW:0]   lg_pack;
    logic [SC_AW-1:0] h_round, avail, by_size;

    always_ff @(posedge clk) begin
        if (rst)       cfg <= '0;
        else if (load) cfg <= cfg_in;
    end

    always_comb begin
        quot    = (cfg.width == '0) ? '0 : cfg.img_pitch / SC_AW'(cfg.width);
        lg_pack = texel_log2(quot);
        bpp_ok  = lg_pack[SC_LW];
        bpp_lg  = lg_pack[SC_LW-1:0];

        h_round = (SC_AW'(cfg.height) + LINE_ALIGN - 1) & ~(LINE_ALIGN - 1);
        avail   = (cfg.size > cfg.offset) ? cfg.size - cfg.offset : '0;
        by_size = (cfg.tile_pitch == '0) ? '0
                : (avail + cfg.tile_pitch - 1) / cfg.tile_pitch;
        tiled_lines = (h_round < by_size) ? h_round : by_size;
    end
endmodule

// File: rtl/surf_walker.sv
module surf_walker
    import surf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [SC_DW-1:0] width,
    input  logic [SC_DW-1:0] height,
    output logic [SC_DW-1:0] row,
    output logic [SC_DW-1:0] col,
    output logic             last
);
    logic col_end;

    assign col_end = (col == width - 1'b1);
    assign last    = col_end && (row == height - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            row <= '0;
            col <= '0;
        end else if (advance) begin
            if (col_end) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // R8: walk stays inside the image
    assert_walk_bounds_R8: assert property (@(posedge clk) disable iff (rst)
        (width != '0 && height != '0) |-> (row < height && col < width));
endmodule

// File: rtl/surf_mover.sv
module surf_mover
    import surf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  cfg_t             cfg,
    input  logic [SC_LW-1:0] bpp_lg,
    input  logic             bpp_ok,
    input  logic [SC_DW-1:0] row,
    input  logic [SC_DW-1:0] col,
    input  logic             last,
    output logic             accept,
    output logic             advance,
    output logic [SC_AW-1:0] xlat_this_addr,
    input  logic [SC_AW-1:0] xlat_tiled_addr,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_lock,
    output logic             mem_buf,
    output logic [SC_AW-1:0] mem_addr,
    output logic [SC_AW-1:0] mem_wdata,
    input  logic             mem_gnt,
    input  logic [SC_AW-1:0] mem_rdata,
    output logic             busy,
    output logic             done
);
    mv_state_e        state;
    logic [SC_AW-1:0] src_idx, dst_idx, hold;
    logic [1:0]       k, k_last;
    logic [SC_AW-1:0] region_start, t_off, l_off, col_bytes;
    logic [SC_AW-1:0] field_mask;
    logic             sub, src_tiled, empty, skip;
    logic [4:0]       src_sh, dst_sh;

    always_comb begin
        region_start   = cfg.base + cfg.offset;
        col_bytes      = SC_AW'(col) << bpp_lg;
        xlat_this_addr = region_start + SC_AW'(row) * cfg.tile_pitch + col_bytes;
        t_off          = xlat_tiled_addr - region_start;
        l_off          = SC_AW'(row) * cfg.img_pitch + col_bytes;
        empty          = (cfg.width == '0) || (cfg.height == '0);
        skip           = !bpp_ok || (t_off >= cfg.size);
        sub            = (bpp_lg < 3'd2);
        src_tiled      = (cfg.dir == DIR_DECODE);
        k_last         = (bpp_lg == 3'd4) ? 2'd3 : (bpp_lg == 3'd3) ? 2'd1 : 2'd0;
        field_mask     = (bpp_lg == 3'd0) ? 32'h0000_00FF : 32'h0000_FFFF;
        src_sh         = lane_shift(src_idx, bpp_lg);
        dst_sh         = lane_shift(dst_idx, bpp_lg);

        accept    = start && (state == MV_IDLE);
        advance   = (state == MV_NEXT) && !last;
        busy      = (state != MV_IDLE);
        done      = (state == MV_DONE);
        mem_req   = (state == MV_RD_SRC) || (state == MV_RD_DST) || (state == MV_WR_DST);
        mem_we    = (state == MV_WR_DST);
        mem_lock  = (state == MV_RD_DST) || ((state == MV_WR_DST) && sub);
        mem_buf   = (state == MV_RD_SRC) ? src_tiled : !src_tiled;
        mem_addr  = (state == MV_RD_SRC) ? texel_word(src_idx, bpp_lg, k)
                                         : texel_word(dst_idx, bpp_lg, k);
        mem_wdata = hold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= MV_IDLE;
            src_idx <= '0;
            dst_idx <= '0;
            hold    <= '0;
            k       <= '0;
        end else begin
            case (state)
                MV_IDLE: if (accept) state <= MV_EVAL;
                MV_EVAL: begin
                    k <= '0;
                    if (empty) begin
                        state <= MV_DONE;
                    end else if (skip) begin
                        state <= MV_NEXT;
                    end else begin
                        src_idx <= src_tiled ? (t_off >> bpp_lg) : (l_off >> bpp_lg);
                        dst_idx <= src_tiled ? (l_off >> bpp_lg) : (t_off >> bpp_lg);
                        state   <= MV_RD_SRC;
                    end
                end
                MV_RD_SRC: if (mem_gnt) begin
                    hold  <= sub ? ((mem_rdata >> src_sh) & field_mask) : mem_rdata;
                    state <= sub ? MV_RD_DST : MV_WR_DST;
                end
                MV_RD_DST: if (mem_gnt) begin
                    hold  <= (mem_rdata & ~(field_mask << dst_sh)) | ((hold & field_mask) << dst_sh);
                    state <= MV_WR_DST;
                end
                MV_WR_DST: if (mem_gnt) begin
                    if (k == k_last) begin
                        state <= MV_NEXT;
                    end else begin
                        k     <= k + 1'b1;
                        state <= MV_RD_SRC;
                    end
                end
                MV_NEXT: state <= last ? MV_DONE : MV_EVAL;
                MV_DONE: state <= MV_IDLE;
                default: state <= MV_IDLE;
            endcase
        end
    end

    // R11: an ungranted request keeps its address, direction and data
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_buf)));

    // R5: the granted destination read is followed by a locked write
    assert_rmw_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_lock && mem_gnt) |=> (mem_req && mem_we && mem_lock));

    // R7: an out-of-region texel issues no request next cycle
    assert_skip_noaccess_R7: assert property (@(posedge clk) disable iff (rst)
        (state == MV_EVAL && !empty && skip) |=> !mem_req);

    // R9: done lasts a single cycle and is followed by idle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R3: an illegal texel size never reaches the memory port
    assert_bad_bpp_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !bpp_ok) |-> !mem_req);
endmodule

// File: rtl/surf_copy_engine.sv
module surf_copy_engine
    import surf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        dir,
    input  logic [15:0] img_width,
    input  logic [15:0] img_height,
    input  logic [31:0] img_pitch,
    input  logic [31:0] tile_pitch,
    input  logic [31:0] region_base,
    input  logic [31:0] region_offset,
    input  logic [31:0] region_size,
    output logic [31:0] xlat_this_addr,
    input  logic [31:0] xlat_tiled_addr,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_lock,
    output logic        mem_buf,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic [31:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] tiled_lines
);
    cfg_t             cfg_in, cfg;
    logic [SC_LW-1:0] bpp_lg;
    logic             bpp_ok, accept, advance, last;
    logic [SC_DW-1:0] row, col;

    always_comb begin
        cfg_in.dir        = dir;
        cfg_in.width      = img_width;
        cfg_in.height     = img_height;
        cfg_in.img_pitch  = img_pitch;
        cfg_in.tile_pitch = tile_pitch;
        cfg_in.base       = region_base;
        cfg_in.offset     = region_offset;
        cfg_in.size       = region_size;
    end

    surf_cfg u_cfg (
        .clk(clk), .rst(rst), .load(accept), .cfg_in(cfg_in), .cfg(cfg),
        .bpp_lg(bpp_lg), .bpp_ok(bpp_ok), .tiled_lines(tiled_lines)
    );

    surf_walker u_walk (
        .clk(clk), .rst(rst), .clear(accept), .advance(advance),
        .width(cfg.width), .height(cfg.height), .row(row), .col(col), .last(last)
    );

    surf_mover u_mov (
        .clk(clk), .rst(rst), .start(start), .cfg(cfg), .bpp_lg(bpp_lg),
        .bpp_ok(bpp_ok), .row(row), .col(col), .last(last), .accept(accept),
        .advance(advance), .xlat_this_addr(xlat_this_addr),
        .xlat_tiled_addr(xlat_tiled_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_lock(mem_lock), .mem_buf(mem_buf), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .busy(busy), .done(done)
    );
endmodule

// File: tb/surf_copy_engine_test.sv
module surf_copy_engine_test;
    localparam logic [31:0] TB_BASE = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dir = 1'b0;
    logic [15:0] img_width = '0, img_height = '0;
    logic [31:0] img_pitch = '0, tile_pitch = '0, region_offset = '0, region_size = '0;
    logic [31:0] xlat_this_addr, xlat_tiled_addr, mem_addr, mem_wdata, mem_rdata, tiled_lines;
    logic        mem_req, mem_we, mem_lock, mem_buf, busy, done;
    logic        mem_gnt = 1'b0;

    logic [31:0] lin_mem [256];
    logic [31:0] til_mem [256];
    logic [31:0] exp_lin [256];
    logic [31:0] exp_til [256];
    int          acc_cnt = 0;
    int          oob_cnt = 0;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    // translator stand-in: swaps bits 5 and 7 of the region-relative address
    function automatic logic [31:0] scramble(input logic [31:0] a);
        logic [31:0] rel, r2;
        rel   = a - TB_BASE;
        r2    = rel;
        r2[5] = rel[7];
        r2[7] = rel[5];
        return TB_BASE + r2;
    endfunction

    assign xlat_tiled_addr = scramble(xlat_this_addr);
    assign mem_rdata = mem_buf ? til_mem[mem_addr[7:0]] : lin_mem[mem_addr[7:0]];

    always @(negedge clk) mem_gnt <= mem_req && ($urandom % 3 != 0);

    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            acc_cnt++;
            if (mem_addr > 32'd255) oob_cnt++;
            if (mem_we) begin
                if (mem_buf) til_mem[mem_addr[7:0]] = mem_wdata;
                else         lin_mem[mem_addr[7:0]] = mem_wdata;
            end
        end
    end

    surf_copy_engine uut (
        .clk(clk), .rst(rst), .start(start), .dir(dir), .img_width(img_width),
        .img_height(img_height), .img_pitch(img_pitch), .tile_pitch(tile_pitch),
        .region_base(TB_BASE), .region_offset(region_offset), .region_size(region_size),
        .xlat_this_addr(xlat_this_addr), .xlat_tiled_addr(xlat_tiled_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_buf(mem_buf),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .tiled_lines(tiled_lines)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic run_case(input bit d, input int w, input int h, input int pitch,
                            input int tp, input int off, input int size, input string tag);
        int bpp, exp_acc, acc0, oob0, wd, bad_lin, bad_til, exp_lines, h64, bysz;
        bit legal;
        for (int i = 0; i < 256; i++) begin
            lin_mem[i] = $urandom; til_mem[i] = $urandom;
            exp_lin[i] = lin_mem[i]; exp_til[i] = til_mem[i];
        end
        bpp = (w == 0) ? 0 : pitch / w;
        legal = (bpp == 1 || bpp == 2 || bpp == 4 || bpp == 8 || bpp == 16);
        exp_acc = 0;
        if (legal) begin
            for (int r = 0; r < h; r++) begin
                for (int c = 0; c < w; c++) begin
                    logic [31:0] th, t, l;
                    th = TB_BASE + off + r * tp + c * bpp;
                    t  = scramble(th) - (TB_BASE + off);
                    if (t >= size) continue;
                    t = (t / bpp) * bpp;
                    l = ((r * pitch + c * bpp) / bpp) * bpp;
                    exp_acc += (bpp >= 4) ? bpp / 2 : 3;
                    for (int b = 0; b < bpp; b++) begin
                        logic [31:0] sa, da;
                        sa = (d ? l : t) + b;
                        da = (d ? t : l) + b;
                        if (d) exp_til[da >> 2][(da % 4) * 8 +: 8] = lin_mem[sa >> 2][(sa % 4) * 8 +: 8];
                        else   exp_lin[da >> 2][(da % 4) * 8 +: 8] = til_mem[sa >> 2][(sa % 4) * 8 +: 8];
                    end
                end
            end
        end
        h64  = ((h + 63) / 64) * 64;
        bysz = (size > off) ? (size - off + tp - 1) / tp : 0;
        exp_lines = (h64 < bysz) ? h64 : bysz;

        @(negedge clk);
        dir = d; img_width = 16'(w); img_height = 16'(h); img_pitch = pitch;
        tile_pitch = tp; region_offset = off; region_size = size;
        acc0 = acc_cnt; oob0 = oob_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", {tag, " busy after start"}, busy, 1);
        wd = 0;
        while (!done && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        check(done == 1'b1, "R9", {tag, " done reached"}, done, 1);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9", {tag, " done single pulse"}, done, 0);
        bad_lin = 0; bad_til = 0;
        for (int i = 0; i < 256; i++) begin
            if (lin_mem[i] !== exp_lin[i]) bad_lin++;
            if (til_mem[i] !== exp_til[i]) bad_til++;
        end
        check(bad_lin == 0, tag, "linear words mismatching", bad_lin, 0);
        check(bad_til == 0, tag, "tiled words mismatching", bad_til, 0);
        check(acc_cnt - acc0 == exp_acc, tag, "access count", acc_cnt - acc0, exp_acc);
        check(oob_cnt == oob0, "R6", {tag, " out-of-range word"}, oob_cnt - oob0, 0);
        check(tiled_lines == exp_lines, "R10", {tag, " tiled_lines"}, tiled_lines, exp_lines);
    endtask

    initial begin
        void'($urandom(32'd7331));
        for (int i = 0; i < 256; i++) begin
            lin_mem[i] = '0; til_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R9", "reset state",
              {busy, done, mem_req}, 0);
        rst = 1'b0;
        @(negedge clk);

        // directed: each legal size in both directions, padded pitches
        run_case(1'b0, 5, 4, 5 * 1 + 3, 128, 16, 1024, "R1_R5_R6");
        run_case(1'b1, 5, 4, 5 * 1 + 2, 128, 0, 1024, "R2_R5_R6");
        run_case(1'b0, 6, 5, 6 * 2 + 5, 128, 32, 1024, "R1_R5");
        run_case(1'b1, 3, 6, 3 * 2, 128, 16, 1024, "R2_R5");
        run_case(1'b0, 4, 6, 4 * 4 + 3, 128, 0, 1024, "R1_R4_R12");
        run_case(1'b1, 6, 4, 6 * 4, 128, 48, 1024, "R2_R4_R12");
        run_case(1'b0, 5, 5, 5 * 8 + 4, 128, 16, 1024, "R1_R4");
        run_case(1'b1, 4, 6, 4 * 8, 128, 0, 1024, "R2_R4");
        run_case(1'b0, 6, 6, 6 * 16 + 5, 128, 32, 1024, "R1_R4");
        run_case(1'b1, 6, 6, 6 * 16, 128, 0, 1024, "R2_R4");
        // illegal quotient, empty image, small region
        run_case(1'b0, 4, 4, 12, 128, 0, 1024, "R3");
        run_case(1'b1, 0, 4, 0, 128, 0, 1024, "R8");
        run_case(1'b0, 4, 0, 16, 128, 0, 1024, "R8");
        run_case(1'b1, 6, 8, 6 * 4, 128, 16, 208, "R7");
        run_case(1'b0, 6, 8, 6 * 16, 128, 0, 96, "R7");

        // random mix
        for (int n = 0; n < 14; n++) begin
            int bpp, w, pad, pitch, hmax, h, off, size;
            case ($urandom % 5)
                0: bpp = 1; 1: bpp = 2; 2: bpp = 4; 3: bpp = 8; default: bpp = 16;
            endcase
            w     = 1 + $urandom % 6;
            pad   = $urandom % w;
            pitch = w * bpp + pad;
            hmax  = 1024 / pitch;
            if (hmax > 8) hmax = 8;
            h     = 1 + $urandom % hmax;
            off   = 16 * ($urandom % 4);
            size  = 256 + 16 * ($urandom % 49);
            run_case(1'($urandom % 2), w, h, pitch, 128, off, size, "R1_R2_R8");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule